// File: doc/BRIEF.md
# Multi-pin configuration write unit

This block holds the pad configuration for a 32-pin port. Each pin has a small configuration byte with four live bits: peripheral-mux enable, input enable, pull enable and drive strength. Each pin also has a 4-bit peripheral-select code. These are stored two per byte, one byte for each adjacent even/odd pin pair. All of this state drives the pad and routing logic of the chip continuously through the output ports. The pad drivers and the peripheral routing themselves are outside the block.

Software can reach the state in two ways. It can write or read the per-pin bytes and per-pair bytes at their own addresses. These writes use byte strobes, so any subset of the four bytes in a word can be written at once. It can also write a single write-only bulk word, which applies one set of configuration bits and/or one peripheral-select code to every pin chosen by a 16-bit mask in one half of the port. That bulk word lets firmware set up a whole bus of pins with a single store.

The bus interface is a single-cycle register port. `busAddr` carries the word address, which is the byte address divided by four. Writes commit on the rising clock edge while `busWe` is high. Read data is combinational from `busAddr`.

Top module: `pincfg_unit`

## Requirements
- R1: After an active-low asynchronous reset, every configuration byte and every peripheral-select nibble is zero, so all pin outputs and all readbacks are zero.
- R2: The configuration byte of pin n sits at byte address 0x40+n. A write to word 0x40+4k updates byte lane j (data bits 8j+7:8j) into pin 4k+j only when byte strobe j is set. Pins whose strobe is clear keep their value.
- R3: Inside a configuration byte, bit 0 drives `pinMuxEn`, bit 1 drives `pinInEn`, bit 2 drives `pinPullEn` and bit 6 drives `pinDrvStr` for that pin, in the cycle after the write.
- R4: The peripheral-select byte for pins 2m and 2m+1 sits at byte address 0x30+m. Its bits 3:0 hold the select of the even pin 2m and its bits 7:4 hold the select of the odd pin 2m+1. The select of pin n appears on `pinSel[4n+3:4n]`, and the same byte-lane/strobe rule as R2 applies.
- R5: A write to byte address 0x28 with bit 30 set loads every selected pin's configuration from the write data: mux enable from bit 16, input enable from bit 17, pull enable from bit 18 and drive strength from bit 22. The byte strobes do not gate this write.
- R6: A write to 0x28 with bit 28 set loads data bits 27:24 into the peripheral-select nibble of every selected pin. Bits 28 and 30 may both be set in one write.
- R7: In a write to 0x28, bit 31 = 0 applies mask bits 15:0 to pins 0–15 (mask bit i selects pin i). Bit 31 = 1 applies the mask to pins 16–31 (mask bit i selects pin 16+i). Pins that are not selected keep their configuration and select.
- R8: A write to 0x28 with both bit 28 and bit 30 clear changes no stored state, whatever the mask and field bits hold.
- R9: Reading 0x28 returns zero. Reading an address outside the configuration and select ranges also returns zero.
- R10: Configuration bytes store only bits 0, 1, 2 and 6. Bits 3, 4, 5 and 7 always read back as zero, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWe | input | 1 | Write request, committed on the rising edge |
| busAddr | input | 5 | Word address (byte address bits 6:2) |
| busBe | input | 4 | Byte strobes for direct byte writes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for `busAddr` |
| pinMuxEn | output | 32 | Per-pin peripheral-mux enable |
| pinInEn | output | 32 | Per-pin input enable |
| pinPullEn | output | 32 | Per-pin pull enable |
| pinDrvStr | output | 32 | Per-pin drive strength |
| pinSel | output | 128 | Per-pin 4-bit peripheral select, pin n at bits 4n+3:4n |

## Verification
The hardest behaviour to expose is the bulk word's selectivity. A fault that writes the wrong half of the port, ignores the mask, or lets one write-enable also drive the other field is invisible unless the pins around the selected set already hold distinct, non-zero values. The stimulus therefore first seeds scattered pins on both halves through direct byte writes with partial strobes. It then issues bulk writes that reach the port's edge pins (0, 15, 16, 31), writes with only one enable, with both, and with neither, and one with all strobes low. After each write, the full output state is compared against a model of every pin.

// File: rtl/pincfg_pkg.sv
`timescale 1ns/1ps
package pincfg_pkg;
  localparam int PIN_COUNT  = 32;
  localparam int PAIR_COUNT = PIN_COUNT / 2;
  localparam int HALF_PINS  = PIN_COUNT / 2;
  localparam int SEL_W      = 4;
  localparam int PIN_W      = $clog2(PIN_COUNT);
  localparam int CFG_WORDS  = PIN_COUNT / 4;
  localparam int SEL_WORDS  = PAIR_COUNT / 4;
  localparam int WIDX_W     = $clog2(CFG_WORDS);

  // live bits of a per-pin configuration byte
  localparam int CB_MUX  = 0;
  localparam int CB_IN   = 1;
  localparam int CB_PULL = 2;
  localparam int CB_DRV  = 6;

  // bulk word fields
  localparam int BK_MASK_LSB = 0;
  localparam int BK_MUX      = 16;
  localparam int BK_IN       = 17;
  localparam int BK_PULL     = 18;
  localparam int BK_DRV      = 22;
  localparam int BK_SEL_LSB  = 24;
  localparam int BK_SELWR    = 28;
  localparam int BK_CFGWR    = 30;
  localparam int BK_HALF     = 31;

  typedef struct packed {
    logic drvStr;
    logic pullEn;
    logic inEn;
    logic muxEn;
  } pinCfg_t;

  typedef struct packed {
    logic [PIN_COUNT-1:0]  cfgWe;    // direct byte write, per pin
    logic [PAIR_COUNT-1:0] selWe;    // direct byte write, per pin pair
    logic                  bulkCfg;  // bulk word carries configuration
    logic                  bulkSel;  // bulk word carries select code
    logic [PIN_COUNT-1:0]  bulkPins; // pins addressed by the bulk word
    logic                  rdCfg;
    logic                  rdSel;
    logic [WIDX_W-1:0]     rdWord;
  } strobe_t;

  function automatic pinCfg_t cfgFromByte(logic [7:0] b);
    pinCfg_t c;
    c.muxEn  = b[CB_MUX];
    c.inEn   = b[CB_IN];
    c.pullEn = b[CB_PULL];
    c.drvStr = b[CB_DRV];
    return c;
  endfunction

  function automatic logic [7:0] cfgToByte(pinCfg_t c);
    logic [7:0] b;
    b = '0;
    b[CB_MUX]  = c.muxEn;
    b[CB_IN]   = c.inEn;
    b[CB_PULL] = c.pullEn;
    b[CB_DRV]  = c.drvStr;
    return b;
  endfunction

  function automatic pinCfg_t cfgFromBulk(logic [31:0] w);
    pinCfg_t c;
    c.muxEn  = w[BK_MUX];
    c.inEn   = w[BK_IN];
    c.pullEn = w[BK_PULL];
    c.drvStr = w[BK_DRV];
    return c;
  endfunction
endpackage

// File: rtl/pincfg_ctrl.sv
`timescale 1ns/1ps
module pincfg_ctrl
  import pincfg_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CFG_WORD  = 16,
  parameter int SEL_WORD  = 12,
  parameter int BULK_WORD = 10
) (
  input  logic                 busWe,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [3:0]           busBe,
  input  logic [HALF_PINS-1:0] bulkMask,
  input  logic                 bulkHalf,
  input  logic                 bulkCfgWr,
  input  logic                 bulkSelWr,
  output strobe_t              strobe
);
  localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_WORD);
  localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(SEL_WORD);
  localparam logic [ADDR_W-1:0] BULK_A = ADDR_W'(BULK_WORD);
  localparam logic [ADDR_W-1:0] CFG_N  = ADDR_W'(CFG_WORDS);
  localparam logic [ADDR_W-1:0] SEL_N  = ADDR_W'(SEL_WORDS);

  logic [ADDR_W-1:0] cfgOff;
  logic [ADDR_W-1:0] selOff;
  logic cfgHit;
  logic selHit;
  logic bulkHit;
  logic bulkFire;

  always_comb begin
    cfgOff   = busAddr - CFG_A;
    selOff   = busAddr - SEL_A;
    cfgHit   = (busAddr >= CFG_A) && (cfgOff < CFG_N);
    selHit   = (busAddr >= SEL_A) && (selOff < SEL_N);
    bulkHit  = (busAddr == BULK_A);
    bulkFire = busWe && bulkHit;
  end

  always_comb begin
    strobe = '0;
    for (int p = 0; p < PIN_COUNT; p++) begin
      strobe.cfgWe[p] = busWe && cfgHit && (cfgOff == ADDR_W'(p / 4)) && busBe[p % 4];
    end
    for (int q = 0; q < PAIR_COUNT; q++) begin
      strobe.selWe[q] = busWe && selHit && (selOff == ADDR_W'(q / 4)) && busBe[q % 4];
    end
    strobe.bulkCfg  = bulkFire && bulkCfgWr;
    strobe.bulkSel  = bulkFire && bulkSelWr;
    strobe.bulkPins = bulkHalf ? {bulkMask, {HALF_PINS{1'b0}}}
                               : {{HALF_PINS{1'b0}}, bulkMask};
    strobe.rdCfg    = cfgHit;
    strobe.rdSel    = selHit;
    strobe.rdWord   = cfgHit ? cfgOff[WIDX_W-1:0] : selOff[WIDX_W-1:0];
  end
endmodule

// File: rtl/pincfg_dp.sv
`timescale 1ns/1ps
module pincfg_dp
  import pincfg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strobe,
  input  logic [31:0]                busWdata,
  output logic [31:0]                busRdata,
  output logic [PIN_COUNT-1:0]       pinMuxEn,
  output logic [PIN_COUNT-1:0]       pinInEn,
  output logic [PIN_COUNT-1:0]       pinPullEn,
  output logic [PIN_COUNT-1:0]       pinDrvStr,
  output logic [PIN_COUNT*SEL_W-1:0] pinSel
);
  logic [7:0]       cfgByte [PIN_COUNT];
  logic [SEL_W-1:0] selNib  [PIN_COUNT];
  pinCfg_t          bulkCfgVal;

  assign bulkCfgVal = cfgFromBulk(busWdata);

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    localparam int LANE     = p % 4;
    localparam int PAIR     = p / 2;
    localparam int PAIRLANE = PAIR % 4;
    localparam int NIB      = p % 2;

    pinCfg_t          cfgQ;
    logic [SEL_W-1:0] selQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgQ <= '0;
      end else if (strobe.cfgWe[p]) begin
        cfgQ <= cfgFromByte(busWdata[8*LANE +: 8]);
      end else if (strobe.bulkCfg && strobe.bulkPins[p]) begin
        cfgQ <= bulkCfgVal;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selQ <= '0;
      end else if (strobe.selWe[PAIR]) begin
        selQ <= busWdata[8*PAIRLANE + SEL_W*NIB +: SEL_W];
      end else if (strobe.bulkSel && strobe.bulkPins[p]) begin
        selQ <= busWdata[BK_SEL_LSB +: SEL_W];
      end
    end

    assign pinMuxEn[p]             = cfgQ.muxEn;
    assign pinInEn[p]              = cfgQ.inEn;
    assign pinPullEn[p]            = cfgQ.pullEn;
    assign pinDrvStr[p]            = cfgQ.drvStr;
    assign pinSel[SEL_W*p +: SEL_W] = selQ;
    assign cfgByte[p]              = cfgToByte(cfgQ);
    assign selNib[p]               = selQ;
  end

  always_comb begin
    logic [PIN_W-1:0] idx;
    busRdata = '0;
    idx      = '0;
    for (int l = 0; l < 4; l++) begin
      if (strobe.rdCfg) begin
        idx = PIN_W'(int'(strobe.rdWord) * 4 + l);
        busRdata[8*l +: 8] = cfgByte[idx];
      end else if (strobe.rdSel) begin
        idx = PIN_W'((int'(strobe.rdWord) * 4 + l) * 2);
        busRdata[8*l +: 8] = {selNib[idx | PIN_W'(1)], selNib[idx]};
      end
    end
  end
endmodule

// File: rtl/pincfg_unit.sv
`timescale 1ns/1ps
module pincfg_unit
  import pincfg_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CFG_WORD  = 16,
  parameter int SEL_WORD  = 12,
  parameter int BULK_WORD = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busWe,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [3:0]                 busBe,
  input  logic [31:0]                busWdata,
  output logic [31:0]                busRdata,
  output logic [PIN_COUNT-1:0]       pinMuxEn,
  output logic [PIN_COUNT-1:0]       pinInEn,
  output logic [PIN_COUNT-1:0]       pinPullEn,
  output logic [PIN_COUNT-1:0]       pinDrvStr,
  output logic [PIN_COUNT*SEL_W-1:0] pinSel
);
  strobe_t strobe;

  pincfg_ctrl #(
    .ADDR_W   (ADDR_W),
    .CFG_WORD (CFG_WORD),
    .SEL_WORD (SEL_WORD),
    .BULK_WORD(BULK_WORD)
  ) u_ctrl (
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busBe    (busBe),
    .bulkMask (busWdata[BK_MASK_LSB +: HALF_PINS]),
    .bulkHalf (busWdata[BK_HALF]),
    .bulkCfgWr(busWdata[BK_CFGWR]),
    .bulkSelWr(busWdata[BK_SELWR]),
    .strobe   (strobe)
  );

  pincfg_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pinMuxEn (pinMuxEn),
    .pinInEn  (pinInEn),
    .pinPullEn(pinPullEn),
    .pinDrvStr(pinDrvStr),
    .pinSel   (pinSel)
  );
endmodule

// File: rtl/pincfg_chk.sv
`timescale 1ns/1ps
module pincfg_chk
  import pincfg_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CFG_WORD  = 16,
  parameter int BULK_WORD = 10
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       busWe,
  input logic [ADDR_W-1:0]          busAddr,
  input logic [HALF_PINS-1:0]       bkMask,
  input logic                       bkHalf,
  input logic                       bkCfgWr,
  input logic                       bkSelWr,
  input logic [SEL_W-1:0]           bkSel,
  input logic                       bkMux,
  input logic                       bkIn,
  input logic                       bkPull,
  input logic                       bkDrv,
  input logic [31:0]                busRdata,
  input logic [PIN_COUNT-1:0]       pinMuxEn,
  input logic [PIN_COUNT-1:0]       pinInEn,
  input logic [PIN_COUNT-1:0]       pinPullEn,
  input logic [PIN_COUNT-1:0]       pinDrvStr,
  input logic [PIN_COUNT*SEL_W-1:0] pinSel
);
  logic                 atBulk;
  logic                 atCfg;
  logic [PIN_COUNT-1:0] chosen;

  assign atBulk = (busAddr == ADDR_W'(BULK_WORD));
  assign atCfg  = (busAddr >= ADDR_W'(CFG_WORD)) && (busAddr < ADDR_W'(CFG_WORD + CFG_WORDS));
  assign chosen = bkHalf ? {bkMask, {HALF_PINS{1'b0}}} : {{HALF_PINS{1'b0}}, bkMask};

  // R1: reset leaves every output at zero
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (pinMuxEn == '0 && pinInEn == '0 && pinPullEn == '0 &&
               pinDrvStr == '0 && pinSel == '0));

  // R9: the bulk word reads as zero
  p_bulk_reads_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    atBulk |-> busRdata == 32'h0);

  // R10: reserved bits of configuration bytes read zero
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    atCfg |-> (busRdata & ~32'h4747_4747) == 32'h0);

  // R8: a bulk write without either enable changes nothing
  p_noop_bulk_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && atBulk && !bkCfgWr && !bkSelWr) |=>
      ($stable(pinMuxEn) && $stable(pinInEn) && $stable(pinPullEn) &&
       $stable(pinDrvStr) && $stable(pinSel)));

  // R5: selected pins take the configuration fields
  p_bulk_cfg_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && atBulk && bkCfgWr) |=>
      (((pinMuxEn  ^ {PIN_COUNT{$past(bkMux)}})  & $past(chosen)) == '0 &&
       ((pinInEn   ^ {PIN_COUNT{$past(bkIn)}})   & $past(chosen)) == '0 &&
       ((pinPullEn ^ {PIN_COUNT{$past(bkPull)}}) & $past(chosen)) == '0 &&
       ((pinDrvStr ^ {PIN_COUNT{$past(bkDrv)}})  & $past(chosen)) == '0));

  // R7: pins outside the mask keep their configuration
  p_bulk_cfg_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && atBulk && bkCfgWr) |=>
      (((pinMuxEn  ^ $past(pinMuxEn))  & ~$past(chosen)) == '0 &&
       ((pinInEn   ^ $past(pinInEn))   & ~$past(chosen)) == '0 &&
       ((pinPullEn ^ $past(pinPullEn)) & ~$past(chosen)) == '0 &&
       ((pinDrvStr ^ $past(pinDrvStr)) & ~$past(chosen)) == '0));

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_chk
    // R6: selected pins take the select code
    p_bulk_sel_load_r6: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && atBulk && bkSelWr && chosen[p]) |=>
        pinSel[SEL_W*p +: SEL_W] == $past(bkSel));
    // R7: unselected pins keep their select code
    p_bulk_sel_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && atBulk && bkSelWr && !chosen[p]) |=>
        $stable(pinSel[SEL_W*p +: SEL_W]));
  end
endmodule

bind pincfg_unit pincfg_chk #(
  .ADDR_W   (ADDR_W),
  .CFG_WORD (CFG_WORD),
  .BULK_WORD(BULK_WORD)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .bkMask   (busWdata[15:0]),
  .bkHalf   (busWdata[31]),
  .bkCfgWr  (busWdata[30]),
  .bkSelWr  (busWdata[28]),
  .bkSel    (busWdata[27:24]),
  .bkMux    (busWdata[16]),
  .bkIn     (busWdata[17]),
  .bkPull   (busWdata[18]),
  .bkDrv    (busWdata[22]),
  .busRdata (busRdata),
  .pinMuxEn (pinMuxEn),
  .pinInEn  (pinInEn),
  .pinPullEn(pinPullEn),
  .pinDrvStr(pinDrvStr),
  .pinSel   (pinSel)
);

// File: tb/tb_pincfg_unit.sv
`timescale 1ns/1ps
module tb_pincfg_unit;
  logic         clk;
  logic         rstN;
  logic         busWe;
  logic [4:0]   busAddr;
  logic [3:0]   busBe;
  logic [31:0]  busWdata;
  logic [31:0]  busRdata;
  logic [31:0]  pinMuxEn, pinInEn, pinPullEn, pinDrvStr;
  logic [127:0] pinSel;

  pincfg_unit dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busBe(busBe),
    .busWdata(busWdata), .busRdata(busRdata), .pinMuxEn(pinMuxEn),
    .pinInEn(pinInEn), .pinPullEn(pinPullEn), .pinDrvStr(pinDrvStr), .pinSel(pinSel)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    bit           isRead;
    logic [31:0]  expRd;
    logic [255:0] expOut;
    string        tag;
  } sbItem_t;

  sbItem_t     sbQ[$];
  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;
  logic [7:0]  mCfg[32];
  logic [3:0]  mSel[32];

  function automatic logic [255:0] modelOuts();
    logic [31:0]  m, i, pl, d;
    logic [127:0] s;
    for (int p = 0; p < 32; p++) begin
      m[p]  = mCfg[p][0];
      i[p]  = mCfg[p][1];
      pl[p] = mCfg[p][2];
      d[p]  = mCfg[p][6];
      s[4*p +: 4] = mSel[p];
    end
    return {m, i, pl, d, s};
  endfunction

  function automatic logic [31:0] modelRead(logic [7:0] byteAddr);
    logic [31:0] r;
    r = '0;
    for (int l = 0; l < 4; l++) begin
      int a;
      a = int'({byteAddr[7:2], 2'b00}) + l;
      if (a >= 'h40 && a < 'h60) r[8*l +: 8] = mCfg[a - 'h40];
      else if (a >= 'h30 && a < 'h40) r[8*l +: 8] = {mSel[2*(a - 'h30) + 1], mSel[2*(a - 'h30)]};
    end
    return r;
  endfunction

  // model of one committed bus write, straight from the requirements
  task automatic modelWrite(logic [7:0] byteAddr, logic [3:0] be, logic [31:0] d);
    if ({byteAddr[7:2], 2'b00} == 8'h28) begin
      for (int p = 0; p < 32; p++) begin
        bit sel;
        sel = d[31] ? (p >= 16 && d[p - 16]) : (p < 16 && d[p]);
        if (sel && d[30]) mCfg[p] = {1'b0, d[22], 3'b000, d[18], d[17], d[16]};
        if (sel && d[28]) mSel[p] = d[27:24];
      end
    end else begin
      for (int l = 0; l < 4; l++) begin
        int a;
        a = int'({byteAddr[7:2], 2'b00}) + l;
        if (be[l]) begin
          if (a >= 'h40 && a < 'h60) mCfg[a - 'h40] = d[8*l +: 8] & 8'h47;
          else if (a >= 'h30 && a < 'h40) begin
            mSel[2*(a - 'h30)]     = d[8*l +: 4];
            mSel[2*(a - 'h30) + 1] = d[8*l + 4 +: 4];
          end
        end
      end
    end
  endtask

  task automatic busWrite(logic [7:0] byteAddr, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = byteAddr[6:2]; busBe = be; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busBe = '0;
    modelWrite(byteAddr, be, d);
  endtask

  task automatic expectOuts(string tag);
    sbItem_t it;
    it.isRead = 0; it.expRd = '0; it.expOut = modelOuts(); it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic expectRead(logic [7:0] byteAddr, string tag);
    sbItem_t it;
    busAddr = byteAddr[6:2];
    it.isRead = 1; it.expRd = modelRead(byteAddr); it.expOut = '0; it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk);
  endtask

  // monitor: pops one expected item per cycle, away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sbQ.size() > 0) begin
        sbItem_t it;
        it = sbQ.pop_front();
        checks++;
        if (it.isRead) begin
          if (busRdata !== it.expRd) begin
            errors++;
            $display("FAIL %s: read got %h expected %h", it.tag, busRdata, it.expRd);
          end
        end else begin
          logic [255:0] act;
          act = {pinMuxEn, pinInEn, pinPullEn, pinDrvStr, pinSel};
          if (act !== it.expOut) begin
            errors++;
            $display("FAIL %s: outputs got %h expected %h", it.tag, act, it.expOut);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 32; p++) begin mCfg[p] = '0; mSel[p] = '0; end
    rstN = 1'b0; busWe = 1'b0; busAddr = '0; busBe = '0; busWdata = '0;
    repeat (3) @(negedge clk);
    expectOuts("R1 outputs during reset");
    rstN = 1'b1;
    expectOuts("R1 outputs after reset");
    expectRead(8'h40, "R1 cfg word 0");
    expectRead(8'h5C, "R1 cfg word 7");
    expectRead(8'h3C, "R1 select word 3");

    // R2/R3/R10: single byte, all bits written, only live bits stored
    busWrite(8'h45, 4'b0010, 32'h0000_FF00);
    expectOuts("R3 pin5 fields");
    expectRead(8'h44, "R10 pin5 reserved bits");
    // R2: partial strobes on the top word
    busWrite(8'h58, 4'b1010, 32'h4102_4401);
    expectOuts("R2 lane strobes pins 24-27");
    expectRead(8'h58, "R2 readback pins 24-27");
    busWrite(8'h40, 4'b0001, 32'hFFFF_FF41);
    expectRead(8'h40, "R2 pin0 only");

    // R4: select byte for pins 6/7 and a full word for pairs 12-15
    busWrite(8'h33, 4'b1000, 32'hA500_0000);
    expectOuts("R4 pins 6 and 7 select");
    busWrite(8'h3C, 4'b1111, 32'h1234_5678);
    expectOuts("R4 pins 24-31 select");
    expectRead(8'h3C, "R4 readback pairs 12-15");
    expectRead(8'h30, "R4 readback pairs 0-3");

    // R5/R7: configuration only, low half, pins 4-7 and pin 15
    busWrite(8'h28, 4'b1111, 32'h4005_80F0);
    expectOuts("R5 low half cfg bulk");
    expectRead(8'h44, "R5 readback pins 4-7");

    // R6/R7: select only, high half edges 16 and 31, strobes all low
    busWrite(8'h28, 4'b0000, 32'h9C00_8001);
    expectOuts("R6 high half select bulk edge pins");

    // R5/R6: both enables, whole high half
    busWrite(8'h28, 4'b1111, 32'hD347_FFFF);
    expectOuts("R5 R6 combined bulk high half");
    expectRead(8'h5C, "R5 readback pins 28-31");

    // R8: neither enable, every other bit set
    busWrite(8'h28, 4'b1111, 32'h2FBF_FFFF);
    expectOuts("R8 no-enable bulk write");
    busWrite(8'h28, 4'b1111, 32'hAFBF_FFFF);
    expectOuts("R8 no-enable bulk write high half");

    // R9: bulk word and unmapped addresses read zero
    expectRead(8'h28, "R9 bulk word readback");
    expectRead(8'h20, "R9 unmapped 0x20");
    expectRead(8'h60, "R9 unmapped 0x60");
    expectRead(8'h00, "R9 unmapped 0x00");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule